// File: doc/BRIEF.md
# Fast Link Pulse Burst Generator

This block produces the pulse bursts a copper Ethernet port sends while it advertises its abilities to a link partner. Each burst carries one 16-bit code word. A burst consists of 17 framing pulses on a regular grid. Between two neighbouring framing pulses, an extra pulse marks a 1 bit and its absence marks a 0 bit. The block repeats the burst at a fixed interval for as long as it is enabled. A free-running period counter starts a burst. A half-slot counter paces the pulses inside it. A four-state machine walks through the 33 half-slots of a burst.

The state machine has four states. FLP_IDLE means the block is disabled. FLP_CLK is the half-slot that holds a framing pulse. FLP_DATA is the half-slot that may hold a data pulse. FLP_WAIT means the burst is done and the block waits for the next period.

The transitions are as follows. In FLP_IDLE, a burst start moves the machine to FLP_CLK. In FLP_WAIT, a burst start also moves it to FLP_CLK. At the end of a FLP_CLK half-slot, the machine goes to FLP_DATA while framing pulses remain, and to FLP_WAIT after the 17th framing pulse. At the end of a FLP_DATA half-slot, the machine goes back to FLP_CLK. From any state, a low enable forces FLP_IDLE.

The default timings assume a 50 MHz clock:
- a pulse is 5 cycles (100 ns);
- a half-slot is 3125 cycles (62.5 µs);
- the burst period is 800000 cycles (16 ms).

A burst therefore lasts about 2 ms. The spacing between framing pulses is 125 µs.

Top module: `flp_burst_gen`

## Requirements
- R1: While reset is asserted, and after it is released with the enable low, `pulse_o` and `busy_o` are 0.
- R2: A burst begins on the first clock edge that samples `en_i` high. While `en_i` stays high, further bursts begin every PERIOD_CYC cycles after that edge.
- R3: A burst holds 17 framing pulses. Framing pulse k starts 2·k·HALF_CYC cycles after the burst start. Every pulse is high for exactly PULSE_CYC cycles.
- R4: Between framing pulses k and k+1 (k = 0..15), a data pulse starts HALF_CYC cycles after framing pulse k if and only if bit k of the code word is 1. Bit 0 is sent first and bit 15 last.
- R5: The code word is captured on the clock edge that starts a burst. A change of `word_i` during a burst takes effect only in the next burst.
- R6: `busy_o` is 1 for exactly 33·HALF_CYC cycles from the burst start, and 0 between bursts.
- R7: The clock edge that samples `en_i` low drives `pulse_o` and `busy_o` to 0 and abandons the burst. No burst starts while `en_i` stays low. The next rising enable starts a fresh burst at once.
- R8: A complete burst contains 17 plus popcount(code word) pulses, which is between 17 and 33.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable for burst generation; low aborts and idles |
| word_i | input | 16 | Code word to send, bit 0 first |
| pulse_o | output | 1 | Pulse train output |
| busy_o | output | 1 | High while a burst is in progress |

## Verification
Three code words are sent in consecutive bursts:
- a mixed pattern (0xA5C3), which distinguishes correct bit order and slot placement from shifted or reversed orderings;
- all zeros, which shows that data slots stay empty and that only the 17 framing pulses appear;
- all ones, which fills every slot.

The word is changed in the middle of a burst to show that capture happens only at burst start. Enable is dropped partway through the all-ones burst to check the abort and the truncated pulse list. Enable is then raised again with word 0x0001 to check that a new burst starts immediately, with a single data pulse in the first slot.

// File: rtl/flp_pkg.sv
package flp_pkg;

    localparam int FLP_WORD_W     = 16;
    localparam int FLP_CLK_PULSES = FLP_WORD_W + 1;
    localparam int FLP_HALF_SLOTS = 2 * FLP_WORD_W + 1;

    typedef enum logic [1:0] {
        FLP_IDLE = 2'd0,
        FLP_CLK  = 2'd1,
        FLP_DATA = 2'd2,
        FLP_WAIT = 2'd3
    } flp_state_e;

endpackage

// File: rtl/flp_period_timer.sv
module flp_period_timer #(
    parameter int PERIOD_CYC = 800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic start_o
);
    localparam int CNT_W = $clog2(PERIOD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign start_o = en_i && (cnt_q == '0);

endmodule

// File: rtl/flp_slot_timer.sv
module flp_slot_timer #(
    parameter int HALF_CYC  = 3125,
    parameter int PULSE_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic head_o,
    output logic last_o
);
    localparam int CNT_W = $clog2(HALF_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] HEAD_SPAN = CNT_W'(PULSE_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign head_o = run_i && (cnt_q < HEAD_SPAN);
    assign last_o = run_i && (cnt_q == CNT_LAST);

endmodule

// File: rtl/flp_burst_gen.sv
module flp_burst_gen
    import flp_pkg::*;
#(
    parameter int PULSE_CYC  = 5,
    parameter int HALF_CYC   = 3125,
    parameter int PERIOD_CYC = 800000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic [FLP_WORD_W-1:0] word_i,
    output logic                  pulse_o,
    output logic                  busy_o
);
    localparam int IDX_W = $clog2(FLP_CLK_PULSES);
    localparam int BIT_W = $clog2(FLP_WORD_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FLP_CLK_PULSES - 1);

    flp_state_e            state_q, state_d;
    logic [IDX_W-1:0]      idx_q;
    logic [FLP_WORD_W-1:0] word_q;
    logic                  start;
    logic                  slot_run;
    logic                  slot_head;
    logic                  slot_last;
    logic                  burst_begin;

    flp_period_timer #(
        .PERIOD_CYC (PERIOD_CYC)
    ) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .start_o (start)
    );

    assign slot_run = en_i && ((state_q == FLP_CLK) || (state_q == FLP_DATA));

    flp_slot_timer #(
        .HALF_CYC  (HALF_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (slot_run),
        .head_o (slot_head),
        .last_o (slot_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLP_IDLE: if (start) state_d = FLP_CLK;
            FLP_CLK: begin
                if (slot_last) begin
                    state_d = (idx_q == IDX_LAST) ? FLP_WAIT : FLP_DATA;
                end
            end
            FLP_DATA: if (slot_last) state_d = FLP_CLK;
            FLP_WAIT: if (start) state_d = FLP_CLK;
            default:  state_d = FLP_IDLE;
        endcase
        if (!en_i) begin
            state_d = FLP_IDLE;
        end
    end

    assign burst_begin = (state_d == FLP_CLK) &&
                         ((state_q == FLP_IDLE) || (state_q == FLP_WAIT));

    // state register with burst bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLP_IDLE;
            idx_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (burst_begin) begin
                idx_q  <= '0;
                word_q <= word_i;
            end else if ((state_q == FLP_DATA) && slot_last) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pulse_o = 1'b0;
        busy_o  = 1'b0;
        unique case (state_q)
            FLP_CLK: begin
                busy_o  = 1'b1;
                pulse_o = slot_head;
            end
            FLP_DATA: begin
                busy_o  = 1'b1;
                pulse_o = slot_head && word_q[idx_q[BIT_W-1:0]];
            end
            default: begin
                busy_o  = 1'b0;
                pulse_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/flp_burst_gen_chk.sv
module flp_burst_gen_chk #(
    parameter int PULSE_CYC  = 5,
    parameter int HALF_CYC   = 3125,
    parameter int PERIOD_CYC = 800000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        en_i,
    input logic        pulse_o,
    input logic        busy_o,
    input logic [15:0] word_q
);
    localparam int BURST_CYC  = 33 * HALF_CYC;
    localparam int MAX_PULSES = 33;

    int   pw_run;
    int   busy_run;
    int   rises;
    logic pulse_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_run     <= 0;
            busy_run   <= 0;
            rises      <= 0;
            pulse_prev <= 1'b0;
        end else begin
            pulse_prev <= pulse_o;
            pw_run     <= pulse_o ? pw_run + 1 : 0;
            busy_run   <= busy_o ? busy_run + 1 : 0;
            if (!busy_o) begin
                rises <= 0;
            end else if (pulse_o && !pulse_prev) begin
                rises <= rises + 1;
            end
        end
    end

    // R3: no pulse stays high longer than PULSE_CYC
    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (pw_run < PULSE_CYC));

    // R3: every burst opens with a framing pulse
    assert_burst_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> pulse_o);

    // R5: captured word holds steady through the burst
    assert_word_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$rose(busy_o)) |-> $stable(word_q));

    // R6: pulses only inside a burst, and a burst never outlasts 33 half-slots
    assert_pulse_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> busy_o);
    assert_burst_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_run < BURST_CYC));

    // R7: a low enable idles the outputs on the next edge
    assert_disable_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!pulse_o && !busy_o));

    // R8: pulse count of a burst is bounded
    assert_pulse_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rises <= MAX_PULSES));

endmodule

bind flp_burst_gen flp_burst_gen_chk #(
    .PULSE_CYC  (PULSE_CYC),
    .HALF_CYC   (HALF_CYC),
    .PERIOD_CYC (PERIOD_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .pulse_o (pulse_o),
    .busy_o  (busy_o),
    .word_q  (word_q)
);

// File: tb/sim_flp_burst_gen.sv
module sim_flp_burst_gen;
    localparam int PULSE  = 2;
    localparam int HALF   = 8;
    localparam int PERIOD = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] word = 16'h0000;
    logic        pulse;
    logic        busy;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int rises = 0;
    int rise_cyc = 0;
    bit prev_pulse = 1'b0;
    bit done = 1'b0;
    int exp_q[$];

    flp_burst_gen #(
        .PULSE_CYC  (PULSE),
        .HALF_CYC   (HALF),
        .PERIOD_CYC (PERIOD)
    ) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .word_i  (word),
        .pulse_o (pulse),
        .busy_o  (busy)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // driver side: expected pulse start cycles, ascending, for offsets below cut
    task automatic push_burst(input int t0, input logic [15:0] w, input int cut);
        for (int k = 0; k < 17; k++) begin
            if (2 * k * HALF < cut) exp_q.push_back(t0 + 2 * k * HALF);
            if (k < 16 && w[k] && ((2 * k + 1) * HALF < cut))
                exp_q.push_back(t0 + (2 * k + 1) * HALF);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // monitor: pops expected starts and checks widths
    always @(negedge clk) begin
        if (rst_n) begin
            if (pulse && !prev_pulse) begin
                rises++;
                rise_cyc = cyc;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected pulse start", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(cyc == e, "R3/R4 pulse start cycle", cyc, e);
                end
            end
            if (!pulse && prev_pulse) begin
                chk((cyc - rise_cyc) == PULSE, "R3 pulse width", cyc - rise_cyc, PULSE);
            end
            prev_pulse = pulse;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int n0;
        int n1;
        repeat (3) @(negedge clk);
        chk(pulse == 1'b0, "R1 pulse in reset", pulse, 0);
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(pulse == 1'b0, "R1 pulse idle after reset", pulse, 0);
        chk(busy == 1'b0, "R1 busy idle after reset", busy, 0);

        word = 16'hA5C3;
        en = 1'b1;
        n0 = cyc + 1;
        push_burst(n0, 16'hA5C3, 1000);
        push_burst(n0 + PERIOD, 16'h0000, 1000);
        push_burst(n0 + 2 * PERIOD, 16'hFFFF, 100);

        wait_cyc(n0);
        chk(busy == 1'b1, "R2 burst starts at enable edge", busy, 1);
        wait_cyc(n0 + 50);
        word = 16'h0000;                         // R5 mid-burst change
        wait_cyc(n0 + 33 * HALF - 1);
        chk(busy == 1'b1, "R6 busy last cycle", busy, 1);
        wait_cyc(n0 + 33 * HALF);
        chk(busy == 1'b0, "R6 busy ends", busy, 0);
        wait_cyc(n0 + PERIOD - 1);
        chk(rises == 25, "R8 pulses in burst 0xA5C3", rises, 25);
        wait_cyc(n0 + PERIOD);
        chk(busy == 1'b1, "R2 second burst at period", busy, 1);
        wait_cyc(n0 + PERIOD + 100);
        word = 16'hFFFF;
        wait_cyc(n0 + 2 * PERIOD - 1);
        chk(rises == 42, "R8 pulses in burst 0x0000", rises, 42);
        wait_cyc(n0 + 2 * PERIOD + 99);
        en = 1'b0;                               // R7 abort mid-burst
        wait_cyc(n0 + 2 * PERIOD + 100);
        chk(pulse == 1'b0, "R7 pulse after disable", pulse, 0);
        chk(busy == 1'b0, "R7 busy after disable", busy, 0);
        wait_cyc(n0 + 3 * PERIOD + 50);
        chk(busy == 1'b0, "R7 no burst while disabled", busy, 0);
        chk(rises == 55, "R7 truncated burst pulse count", rises, 55);
        chk(exp_q.size() == 0, "R4 expected pulses all seen", exp_q.size(), 0);

        word = 16'h0001;
        en = 1'b1;
        n1 = cyc + 1;
        push_burst(n1, 16'h0001, 1000);
        wait_cyc(n1);
        chk(busy == 1'b1, "R7 fresh burst on re-enable", busy, 1);
        wait_cyc(n1 + 299);
        en = 1'b0;
        wait_cyc(n1 + 310);
        chk(rises == 55 + 18, "R8 pulses in burst 0x0001", rises, 73);
        chk(exp_q.size() == 0, "R4 expected pulses all seen", exp_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule